// File: doc/BRIEF.md
# Byte-Opcode SPI Transaction Sequencer

This block is a half-duplex SPI master whose transfers are run by a small program instead of one shift per host access. The host loads a 64-bit program word holding eight one-byte opcodes. The engine executes them one after another. The opcodes assert or release a chip select, send bytes taken from a 64-bit transmit data register, collect bytes into a 64-bit receive data register, jump to another slot, or stop. Each data register has a full flag, and these flags form the handshake with the host. The host refills the transmit register while a long send is waiting, and it drains the receive register after a collect.

The host reaches the block through a simple indexed register port. A write strobe and a read strobe share a 4-bit index, and read data is returned in the same cycle. The serial side runs in SPI mode 0. The most significant bit goes first. The clock divider is programmable. A two-step key written to the clock configuration register aborts the engine. A write to the status register clears the sticky error flags.

Top module: `spi_seq_engine`

## Requirements
- R1: After reset, status (index 8) reads 0x0001_0000_0000_0000: the state field in bits 55:48 is 0x01, which means idle, and no flag is set. All chip selects are high and SCK is low.
- R2: Opcodes run from bits 63:56 of the program (index 7) downward. Opcode 0x1n with n>0 drives chip select n-1 low and releases the others. Opcode 0x10 releases all chip selects. At most one chip select is low at any time.
- R3: Opcode 0x3n sends n bytes in mode 0, MSB first. MOSI is held while SCK rises. The bytes come from the transmit register (index 5) starting at bits 63:56.
- R4: The SCK period is 2*(D+1) system clocks, where D is clock-config (index 3) bits 63:52.
- R5: A host write to the transmit register sets status bit 59. The bit clears when the engine takes the data. A write while bit 59 is set is dropped and sets status bit 58.
- R6: A send of more than 8 bytes stalls after each eighth byte. During the stall the state is 0x04, bit 59 is clear and SCK is low. The send resumes only after the host writes the transmit register again.
- R7: Opcode 0x4n collects n bytes right-aligned, so the last byte lands in bits 7:0. Collected data is moved to the receive register (index 6) at the end of the opcode and after every eighth byte, and each move sets status bit 63. A host read of the receive register clears bit 63.
- R8: Reading the receive register while bit 63 is clear sets status bit 61. A move while bit 63 is set overwrites the receive register and sets status bit 62.
- R9: Opcode 0x00 and completion of slot 7 both return the engine to idle with the chip selects unchanged. Opcode 0xEn jumps to slot n[2:0], where slot 0 is bits 63:56. Opcode 0xC0 does nothing.
- R10: Any other opcode sets status bit 12, releases all chip selects and returns to idle.
- R11: A clock-config write with bits 36 and 38 set, followed by one with bits 37 and 39 set, aborts the engine. After the abort the state is idle, chip selects are released, bits 59 and 63 are clear, and stored clock-config is unchanged. Any write to status clears bits 58, 61, 62 and 12.
- R12: Counter config (1), clock config (3), port control (9), program (7) and transmit data (5) read back what they hold. The remaining indices read zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (side effects on index 6) |
| reg_idx | input | 4 | Register index |
| reg_wdata | input | 64 | Write data |
| reg_rdata | output | 64 | Read data for reg_idx, same cycle |
| spi_sck | output | 1 | Serial clock, idles low |
| spi_mosi | output | 1 | Serial data out |
| spi_miso | input | 1 | Serial data in |
| spi_cs_n | output | NCS | Active-low chip selects |

## Verification
The hardest state to reach from the ports is the mid-opcode stall of a long send. The engine waits with SCK low after eight bytes, and nothing is visible outside it except the state field. The bench loads the transmit register before starting the program, so the first take is immediate. It then counts bytes at the slave model, waits until eight have been seen, and polls status for the wait code before it writes the second chunk. The abort key is applied the same way, while the engine is parked in that wait with a collected byte still unread.

// File: rtl/spi_seq_pkg.sv
package spi_seq_pkg;

   localparam int DWORD = 64;

   localparam logic [3:0] IX_ERR  = 4'd0;
   localparam logic [3:0] IX_CNT  = 4'd1;
   localparam logic [3:0] IX_CFG1 = 4'd2;
   localparam logic [3:0] IX_CLK  = 4'd3;
   localparam logic [3:0] IX_MMAP = 4'd4;
   localparam logic [3:0] IX_TX   = 4'd5;
   localparam logic [3:0] IX_RX   = 4'd6;
   localparam logic [3:0] IX_SEQ  = 4'd7;
   localparam logic [3:0] IX_STAT = 4'd8;
   localparam logic [3:0] IX_PORT = 4'd9;

   // status bit positions
   localparam int SB_RX_FULL = 63;
   localparam int SB_RX_OVR  = 62;
   localparam int SB_RX_UDR  = 61;
   localparam int SB_TX_FULL = 59;
   localparam int SB_TX_OVR  = 58;
   localparam int SB_STATE   = 48;
   localparam int SB_BADOP   = 12;

   // clock config fields
   localparam int CK_DIV_LSB = 52;

   typedef enum logic [7:0] {
      ST_IDLE   = 8'h01,
      ST_DECODE = 8'h02,
      ST_TXWAIT = 8'h04,
      ST_XFER   = 8'h08
   } seq_state_e;

   localparam logic [3:0] OPG_STOP = 4'h0;
   localparam logic [3:0] OPG_SEL  = 4'h1;
   localparam logic [3:0] OPG_OUT  = 4'h3;
   localparam logic [3:0] OPG_IN   = 4'h4;
   localparam logic [3:0] OPG_COPY = 4'hC;
   localparam logic [3:0] OPG_JUMP = 4'hE;

endpackage

// File: rtl/spi_seq_clkgen.sv
module spi_seq_clkgen #(
   parameter int DIV_W = 12
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             en,
   input  logic [DIV_W-1:0] div,
   output logic             tick
);

   logic [DIV_W-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          cnt_q <= '0;
      else if (!en)        cnt_q <= '0;
      else if (cnt_q >= div) cnt_q <= '0;
      else                 cnt_q <= cnt_q + 1'b1;
   end

   assign tick = en && (cnt_q >= div);

   // R4: one half period of SCK spans div+1 cycles, so ticks never abut unless div is 0
   p_tick_spacing_r4: assert property (@(posedge clk) disable iff (!rst_n)
      tick |=> (!tick || div == '0));

endmodule

// File: rtl/spi_seq_shifter.sv
module spi_seq_shifter (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       abort,
   input  logic       start,
   input  logic [7:0] tx_byte,
   input  logic       tick,
   input  logic       miso,
   output logic       busy,
   output logic       done,
   output logic [7:0] rx_byte,
   output logic       sck,
   output logic       mosi
);

   logic       busy_q, sck_q, done_q;
   logic [7:0] sh_q, rx_q;
   logic [2:0] bit_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy_q <= 1'b0;
         sck_q  <= 1'b0;
         done_q <= 1'b0;
         sh_q   <= '0;
         rx_q   <= '0;
         bit_q  <= '0;
      end else begin
         done_q <= 1'b0;
         if (abort) begin
            busy_q <= 1'b0;
            sck_q  <= 1'b0;
         end else if (!busy_q) begin
            if (start) begin
               busy_q <= 1'b1;
               sck_q  <= 1'b0;
               sh_q   <= tx_byte;
               bit_q  <= '0;
            end
         end else if (tick) begin
            if (!sck_q) begin
               sck_q <= 1'b1;
               rx_q  <= {rx_q[6:0], miso};
            end else begin
               sck_q <= 1'b0;
               if (bit_q == 3'd7) begin
                  busy_q <= 1'b0;
                  done_q <= 1'b1;
               end else begin
                  bit_q <= bit_q + 1'b1;
                  sh_q  <= {sh_q[6:0], 1'b0};
               end
            end
         end
      end
   end

   assign busy    = busy_q;
   assign done    = done_q;
   assign rx_byte = rx_q;
   assign sck     = sck_q;
   assign mosi    = sh_q[7];

   // R3: mode 0 keeps the clock low between bytes
   p_sck_idle_r3: assert property (@(posedge clk) disable iff (!rst_n)
      !busy_q |-> !sck_q);

   // R3: data out never moves on the sampling edge
   p_mosi_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(sck_q) |-> $stable(sh_q[7]));

endmodule

// File: rtl/spi_seq_ctrl.sv
module spi_seq_ctrl
   import spi_seq_pkg::*;
#(
   parameter int NCS = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             seq_load,
   input  logic [DWORD-1:0] seq_prog,
   input  logic             tx_wr,
   input  logic [DWORD-1:0] tx_wdata,
   input  logic             rx_rd,
   input  logic             stat_clr,
   input  logic             soft_rst,
   input  logic             sh_done,
   input  logic [7:0]       sh_rx_byte,
   output logic             sh_start,
   output logic [7:0]       sh_byte,
   output seq_state_e       state,
   output logic [DWORD-1:0] prog,
   output logic [DWORD-1:0] tx_data,
   output logic [DWORD-1:0] rx_data,
   output logic             tx_full,
   output logic             tx_ovr,
   output logic             rx_full,
   output logic             rx_udr,
   output logic             rx_ovr,
   output logic             bad_op,
   output logic [NCS-1:0]   cs_n
);

   localparam int SEL_W = 4;

   seq_state_e       state_q, state_d;
   logic [DWORD-1:0] prog_q, prog_d, txbuf_q, txbuf_d, acc_q, acc_d, acc_n;
   logic [DWORD-1:0] tx_q, tx_d, rx_q, rx_d;
   logic [2:0]       ptr_q, ptr_d;
   logic [SEL_W-1:0] sel_q, sel_d;
   logic [3:0]       rem_q, rem_d, txleft_q, txleft_d, incnt_q, incnt_d;
   logic             dir_out_q, dir_out_d;
   logic             tx_full_q, tx_full_d, tx_ovr_q, tx_ovr_d;
   logic             rx_full_q, rx_full_d, rx_udr_q, rx_udr_d, rx_ovr_q, rx_ovr_d;
   logic             err_q, err_d, adv;
   logic [7:0]       op;

   assign op = prog_q[{3'd7 - ptr_q, 3'b000} +: 8];

   always_comb begin
      state_d   = state_q;   prog_d   = prog_q;   ptr_d    = ptr_q;
      sel_d     = sel_q;     rem_d    = rem_q;    dir_out_d = dir_out_q;
      txbuf_d   = txbuf_q;   txleft_d = txleft_q; acc_d    = acc_q;
      incnt_d   = incnt_q;   tx_d     = tx_q;     tx_full_d = tx_full_q;
      tx_ovr_d  = tx_ovr_q;  rx_d     = rx_q;     rx_full_d = rx_full_q;
      rx_udr_d  = rx_udr_q;  rx_ovr_d = rx_ovr_q; err_d    = err_q;
      sh_start  = 1'b0;      sh_byte  = '0;       adv      = 1'b0;
      acc_n     = '0;

      // host side of the handshakes
      if (stat_clr) begin
         tx_ovr_d = 1'b0; rx_udr_d = 1'b0; rx_ovr_d = 1'b0; err_d = 1'b0;
      end
      if (tx_wr) begin
         if (tx_full_q) tx_ovr_d = 1'b1;
         else begin
            tx_d      = tx_wdata;
            tx_full_d = 1'b1;
         end
      end
      if (rx_rd) begin
         if (rx_full_q) rx_full_d = 1'b0;
         else           rx_udr_d  = 1'b1;
      end

      // sequencer side
      unique case (state_q)
         ST_IDLE: begin
            if (seq_load) begin
               prog_d  = seq_prog;
               ptr_d   = '0;
               state_d = ST_DECODE;
            end
         end
         ST_DECODE: begin
            unique case (op[7:4])
               OPG_STOP: begin
                  if (op[3:0] == 4'h0) state_d = ST_IDLE;
                  else begin
                     err_d = 1'b1; sel_d = '0; state_d = ST_IDLE;
                  end
               end
               OPG_SEL: begin
                  sel_d = op[3:0];
                  adv   = 1'b1;
               end
               OPG_OUT: begin
                  if (op[3:0] == 4'h0) adv = 1'b1;
                  else begin
                     rem_d     = op[3:0];
                     dir_out_d = 1'b1;
                     state_d   = ST_TXWAIT;
                  end
               end
               OPG_IN: begin
                  if (op[3:0] == 4'h0) adv = 1'b1;
                  else begin
                     rem_d     = op[3:0];
                     dir_out_d = 1'b0;
                     acc_d     = '0;
                     incnt_d   = '0;
                     sh_start  = 1'b1;
                     state_d   = ST_XFER;
                  end
               end
               OPG_COPY: begin
                  if (op[3:0] == 4'h0) adv = 1'b1;
                  else begin
                     err_d = 1'b1; sel_d = '0; state_d = ST_IDLE;
                  end
               end
               OPG_JUMP: ptr_d = op[2:0];
               default: begin
                  err_d = 1'b1; sel_d = '0; state_d = ST_IDLE;
               end
            endcase
         end
         ST_TXWAIT: begin
            if (tx_full_q) begin
               txbuf_d   = tx_q;
               tx_full_d = 1'b0;
               txleft_d  = 4'd8;
               sh_start  = 1'b1;
               sh_byte   = tx_q[63:56];
               state_d   = ST_XFER;
            end
         end
         ST_XFER: begin
            if (sh_done) begin
               rem_d = rem_q - 1'b1;
               if (dir_out_q) begin
                  txbuf_d  = {txbuf_q[55:0], 8'h00};
                  txleft_d = txleft_q - 1'b1;
                  if (rem_q == 4'd1)         adv = 1'b1;
                  else if (txleft_q == 4'd1) state_d = ST_TXWAIT;
                  else begin
                     sh_start = 1'b1;
                     sh_byte  = txbuf_q[55:48];
                  end
               end else begin
                  acc_n = {acc_q[55:0], sh_rx_byte};
                  if (rem_q == 4'd1 || incnt_q == 4'd7) begin
                     rx_d = acc_n;
                     if (rx_full_d) rx_ovr_d = 1'b1;
                     rx_full_d = 1'b1;
                     acc_d     = '0;
                     incnt_d   = '0;
                  end else begin
                     acc_d   = acc_n;
                     incnt_d = incnt_q + 1'b1;
                  end
                  if (rem_q == 4'd1) adv = 1'b1;
                  else               sh_start = 1'b1;
               end
            end
         end
         default: state_d = ST_IDLE;
      endcase

      if (adv) begin
         if (ptr_q == 3'd7) state_d = ST_IDLE;
         else begin
            ptr_d   = ptr_q + 1'b1;
            state_d = ST_DECODE;
         end
      end

      if (soft_rst) begin
         state_d   = ST_IDLE;
         sel_d     = '0;
         tx_full_d = 1'b0;
         rx_full_d = 1'b0;
         sh_start  = 1'b0;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ST_IDLE; prog_q <= '0; ptr_q <= '0; sel_q <= '0;
         rem_q <= '0; dir_out_q <= 1'b0; txbuf_q <= '0; txleft_q <= '0;
         acc_q <= '0; incnt_q <= '0; tx_q <= '0; tx_full_q <= 1'b0;
         tx_ovr_q <= 1'b0; rx_q <= '0; rx_full_q <= 1'b0; rx_udr_q <= 1'b0;
         rx_ovr_q <= 1'b0; err_q <= 1'b0;
      end else begin
         state_q <= state_d; prog_q <= prog_d; ptr_q <= ptr_d; sel_q <= sel_d;
         rem_q <= rem_d; dir_out_q <= dir_out_d; txbuf_q <= txbuf_d; txleft_q <= txleft_d;
         acc_q <= acc_d; incnt_q <= incnt_d; tx_q <= tx_d; tx_full_q <= tx_full_d;
         tx_ovr_q <= tx_ovr_d; rx_q <= rx_d; rx_full_q <= rx_full_d; rx_udr_q <= rx_udr_d;
         rx_ovr_q <= rx_ovr_d; err_q <= err_d;
      end
   end

   for (genvar i = 0; i < NCS; i++) begin : g_cs
      assign cs_n[i] = !(sel_q == SEL_W'(i + 1));
   end

   assign state   = state_q;
   assign prog    = prog_q;
   assign tx_data = tx_q;
   assign rx_data = rx_q;
   assign tx_full = tx_full_q;
   assign tx_ovr  = tx_ovr_q;
   assign rx_full = rx_full_q;
   assign rx_udr  = rx_udr_q;
   assign rx_ovr  = rx_ovr_q;
   assign bad_op  = err_q;

   // R2: never more than one device selected
   p_cs_onehot_r2: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(~cs_n));

   // R5: a pending transmit word is consumed in the cycle the engine waits for it
   p_take_clears_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_TXWAIT && tx_full_q) |=> !tx_full_q);

   // R10: an undefined opcode halts and releases the bus
   p_bad_op_halts_r10: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(err_q) |-> (state_q == ST_IDLE && sel_q == '0));

   // R8: overrun only arises on top of an unread word
   p_ovr_needs_full_r8: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rx_ovr_q) |-> rx_full_q);

endmodule

// File: rtl/spi_seq_engine.sv
module spi_seq_engine
   import spi_seq_pkg::*;
#(
   parameter int NCS   = 4,
   parameter int DIV_W = 12
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           reg_wr,
   input  logic           reg_rd,
   input  logic [3:0]     reg_idx,
   input  logic [63:0]    reg_wdata,
   output logic [63:0]    reg_rdata,
   output logic           spi_sck,
   output logic           spi_mosi,
   input  logic           spi_miso,
   output logic [NCS-1:0] spi_cs_n
);

   if (NCS < 1 || NCS > 15) begin : g_bad_ncs
      $error("NCS must lie in 1..15");
   end
   if (DIV_W < 1 || DIV_W > 12) begin : g_bad_div
      $error("DIV_W must lie in 1..12");
   end

   logic [DWORD-1:0] cnt_cfg_q, clk_cfg_q, port_q;
   logic             key_armed_q;
   logic             wr_clk, key_first, key_second, soft_rst;
   logic             seq_load, tx_wr, rx_rd, stat_clr;

   assign wr_clk     = reg_wr && reg_idx == IX_CLK;
   assign key_first  = reg_wdata[36] && reg_wdata[38];
   assign key_second = reg_wdata[37] && reg_wdata[39];
   assign soft_rst   = wr_clk && key_armed_q && key_second && !key_first;
   assign seq_load   = reg_wr && reg_idx == IX_SEQ;
   assign tx_wr      = reg_wr && reg_idx == IX_TX;
   assign rx_rd      = reg_rd && reg_idx == IX_RX;
   assign stat_clr   = reg_wr && reg_idx == IX_STAT;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_cfg_q   <= '0;
         clk_cfg_q   <= '0;
         port_q      <= '0;
         key_armed_q <= 1'b0;
      end else begin
         if (reg_wr && reg_idx == IX_CNT)  cnt_cfg_q <= reg_wdata;
         if (reg_wr && reg_idx == IX_PORT) port_q    <= reg_wdata;
         if (wr_clk) begin
            if (key_first)                      key_armed_q <= 1'b1;
            else if (key_armed_q && key_second) key_armed_q <= 1'b0;
            else begin
               clk_cfg_q   <= reg_wdata;
               key_armed_q <= 1'b0;
            end
         end
      end
   end

   seq_state_e       state;
   logic [DWORD-1:0] prog, tx_data, rx_data;
   logic             tx_full, tx_ovr, rx_full, rx_udr, rx_ovr, bad_op;
   logic             sh_start, sh_done, sh_busy, tick;
   logic [7:0]       sh_byte, sh_rx_byte;

   spi_seq_ctrl #(.NCS(NCS)) u_ctrl (
      .clk, .rst_n, .seq_load, .seq_prog(reg_wdata), .tx_wr, .tx_wdata(reg_wdata),
      .rx_rd, .stat_clr, .soft_rst, .sh_done, .sh_rx_byte, .sh_start, .sh_byte,
      .state, .prog, .tx_data, .rx_data, .tx_full, .tx_ovr, .rx_full, .rx_udr,
      .rx_ovr, .bad_op, .cs_n(spi_cs_n)
   );

   spi_seq_clkgen #(.DIV_W(DIV_W)) u_clkgen (
      .clk, .rst_n, .en(sh_busy), .div(clk_cfg_q[CK_DIV_LSB +: DIV_W]), .tick
   );

   spi_seq_shifter u_shift (
      .clk, .rst_n, .abort(soft_rst), .start(sh_start), .tx_byte(sh_byte), .tick,
      .miso(spi_miso), .busy(sh_busy), .done(sh_done), .rx_byte(sh_rx_byte),
      .sck(spi_sck), .mosi(spi_mosi)
   );

   logic [DWORD-1:0] status;
   always_comb begin
      status = '0;
      status[SB_RX_FULL] = rx_full;
      status[SB_RX_OVR]  = rx_ovr;
      status[SB_RX_UDR]  = rx_udr;
      status[SB_TX_FULL] = tx_full;
      status[SB_TX_OVR]  = tx_ovr;
      status[SB_STATE +: 8] = state;
      status[SB_BADOP]   = bad_op;
   end

   always_comb begin
      unique case (reg_idx)
         IX_CNT:  reg_rdata = cnt_cfg_q;
         IX_CLK:  reg_rdata = clk_cfg_q;
         IX_TX:   reg_rdata = tx_data;
         IX_RX:   reg_rdata = rx_data;
         IX_SEQ:  reg_rdata = prog;
         IX_STAT: reg_rdata = status;
         IX_PORT: reg_rdata = port_q;
         default: reg_rdata = '0;
      endcase
   end

   // R11: the second half of the key leaves everything parked
   p_key_aborts_r11: assert property (@(posedge clk) disable iff (!rst_n)
      soft_rst |=> (state == ST_IDLE && !tx_full && !rx_full && &spi_cs_n && !spi_sck));

   // R8: an empty read leaves a mark unless status is being cleared at once
   p_rx_underrun_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (rx_rd && !rx_full && !stat_clr) |=> rx_udr);

   // R6: a stalled send holds the serial clock low
   p_stall_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_TXWAIT) |-> !spi_sck);

endmodule

// File: tb/spi_seq_engine_bench.sv
`timescale 1ns/1ps
module spi_seq_engine_bench;

   localparam int NCS = 4;
   localparam logic [63:0] IDLE_ST = 64'h0001_0000_0000_0000;
   localparam logic [63:0] CLKCFG  = 64'h0018_0000_0000_0000; // divider 1, bit 51 set

   logic           clk = 1'b0;
   logic           rst_n = 1'b0;
   logic           reg_wr = 1'b0, reg_rd = 1'b0;
   logic [3:0]     reg_idx = '0;
   logic [63:0]    reg_wdata = '0;
   logic [63:0]    reg_rdata;
   logic           spi_sck, spi_mosi;
   logic           spi_miso = 1'b0;
   logic [NCS-1:0] spi_cs_n;

   always #5 clk = ~clk;

   spi_seq_engine #(.NCS(NCS)) u_spi_seq_engine (
      .clk, .rst_n, .reg_wr, .reg_rd, .reg_idx, .reg_wdata, .reg_rdata,
      .spi_sck, .spi_mosi, .spi_miso, .spi_cs_n
   );

   int checks = 0, fails = 0;
   logic [7:0]     exp_q[$];
   logic [7:0]     resp_q[$];
   logic [7:0]     resp_cur = '0;
   logic [NCS-1:0] exp_cs = '1;
   int             bitidx = 0, bytes_seen = 0;
   logic [7:0]     cap = '0;
   bit             per_chk = 0;
   realtime        last_rise = 0;

   task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   // scoreboard monitor: slave model on the serial side
   always @(posedge spi_sck) begin
      if (per_chk && bitidx != 0) chk("R4 sck period ns", 64'(int'($realtime - last_rise)), 64'd40);
      last_rise = $realtime;
      cap = {cap[6:0], spi_mosi};
      bitidx++;
      if (bitidx == 8) begin
         bitidx = 0;
         bytes_seen++;
         chk("R2 chip select during byte", 64'(spi_cs_n), 64'(exp_cs));
         if (exp_q.size() == 0) chk("R3 unexpected byte", 64'(cap), 64'hXX);
         else chk("R3 byte on MOSI", 64'(cap), 64'(exp_q.pop_front()));
         resp_cur = (resp_q.size() != 0) ? resp_q.pop_front() : 8'h00;
      end
   end
   always @(negedge spi_sck) spi_miso <= resp_cur[7 - bitidx];

   task automatic wr(input logic [3:0] idx, input logic [63:0] d);
      @(negedge clk);
      reg_wr = 1'b1; reg_idx = idx; reg_wdata = d;
      @(negedge clk);
      reg_wr = 1'b0;
   endtask

   task automatic rd(input logic [3:0] idx, output logic [63:0] d);
      @(negedge clk);
      reg_rd = 1'b1; reg_idx = idx;
      #1 d = reg_rdata;
      @(negedge clk);
      reg_rd = 1'b0;
   endtask

   task automatic wait_state(input logic [7:0] st);
      logic [63:0] s;
      for (int i = 0; i < 4000; i++) begin
         rd(4'd8, s);
         if (s[55:48] == st) return;
      end
      chk("wait for state", 64'(s[55:48]), 64'(st));
   endtask

   task automatic expect_bytes(input logic [63:0] w, input int n);
      for (int i = 0; i < n; i++) exp_q.push_back(w[63-8*i -: 8]);
   endtask

   task automatic prime();
      resp_cur = resp_q.pop_front();
      spi_miso = resp_cur[7];
   endtask

   initial begin
      #2_000_000;
      fails++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

   initial begin
      logic [63:0] v;
      int base;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // R1 reset state
      rd(4'd8, v); chk("R1 status after reset", v, IDLE_ST);
      chk("R1 chip selects", 64'(spi_cs_n), 64'hF);
      chk("R1 sck idle", 64'(spi_sck), 64'd0);

      // R12 register readback
      wr(4'd1, 64'h0123_4567_89AB_CDEF);
      wr(4'd9, 64'hFEDC_0000_0000_1234);
      wr(4'd3, CLKCFG);
      wr(4'd2, 64'hFFFF_FFFF_FFFF_FFFF);
      rd(4'd1, v); chk("R12 counter cfg", v, 64'h0123_4567_89AB_CDEF);
      rd(4'd9, v); chk("R12 port ctrl", v, 64'hFEDC_0000_0000_1234);
      rd(4'd3, v); chk("R12 clock cfg", v, CLKCFG);
      rd(4'd2, v); chk("R12 unused index", v, 64'd0);
      rd(4'd0, v); chk("R12 error index", v, 64'd0);

      // R5 transmit handshake, R3/R2 basic send
      wr(4'd5, 64'hA1B2_C3D4_E5F6_0718);
      rd(4'd8, v); chk("R5 tx full after write", 64'(v[59]), 64'd1);
      wr(4'd5, 64'h1111_1111_1111_1111);
      rd(4'd8, v); chk("R5 tx overrun", 64'(v[58]), 64'd1);
      rd(4'd5, v); chk("R5 dropped write", v, 64'hA1B2_C3D4_E5F6_0718);
      wr(4'd8, 64'd0);
      rd(4'd8, v); chk("R11 status clear keeps tx full", v, IDLE_ST | (64'd1 << 59));
      exp_cs = 4'b1110;
      expect_bytes(64'hA1B2_C300_0000_0000, 3);
      wr(4'd7, 64'h1133_1000_0000_0000);
      rd(4'd7, v); chk("R12 program readback", v, 64'h1133_1000_0000_0000);
      wait_state(8'h01);
      rd(4'd8, v); chk("R5 tx taken", v, IDLE_ST);
      chk("R2 deselect", 64'(spi_cs_n), 64'hF);

      // R6 long send with refill, R4 period
      per_chk = 1;
      exp_cs = 4'b1101;
      base = bytes_seen;
      wr(4'd5, 64'h0102_0304_0506_0708);
      expect_bytes(64'h0102_0304_0506_0708, 8);
      wr(4'd7, 64'h123A_1000_0000_0000);
      wait (bytes_seen == base + 8);
      wait_state(8'h04);
      rd(4'd8, v);
      chk("R6 stalled with tx empty", 64'(v[59]), 64'd0);
      chk("R6 eight bytes before stall", 64'(bytes_seen - base), 64'd8);
      chk("R6 sck low in stall", 64'(spi_sck), 64'd0);
      expect_bytes(64'h090A_0000_0000_0000, 2);
      wr(4'd5, 64'h090A_FFFF_FFFF_FFFF);
      wait_state(8'h01);
      per_chk = 0;
      chk("R6 total bytes", 64'(bytes_seen - base), 64'd10);

      // R7 collect
      exp_cs = 4'b1110;
      wr(4'd5, 64'h9F00_0000_0000_0000);
      expect_bytes(64'h9F00_0000_0000_0000, 4);
      resp_q.push_back(8'h00); resp_q.push_back(8'h5A);
      resp_q.push_back(8'h3C); resp_q.push_back(8'hE7);
      prime();
      wr(4'd7, 64'h1131_4310_0000_0000);
      wait_state(8'h01);
      rd(4'd8, v); chk("R7 rx full", 64'(v[63]), 64'd1);
      rd(4'd6, v); chk("R7 right-aligned data", v, 64'h0000_0000_005A_3CE7);
      rd(4'd8, v); chk("R7 rx full cleared by read", v, IDLE_ST);

      // R8 underrun and overrun
      rd(4'd6, v);
      rd(4'd8, v); chk("R8 rx underrun", 64'(v[61]), 64'd1);
      expect_bytes(64'd0, 8); expect_bytes(64'd0, 1);
      for (int i = 0; i < 9; i++) resp_q.push_back(8'h11 + 8'(i));
      prime();
      wr(4'd7, 64'h1149_1000_0000_0000);
      wait_state(8'h01);
      rd(4'd8, v); chk("R8 rx overrun", 64'(v[62]), 64'd1);
      rd(4'd6, v); chk("R8 overwrite keeps last byte", v, 64'h0000_0000_0000_0019);
      wr(4'd8, 64'd0);
      rd(4'd8, v); chk("R11 status clear", v, IDLE_ST);

      // R9 branch, copy, stop, end of slots
      wr(4'd5, 64'h7700_0000_0000_0000);
      expect_bytes(64'h7700_0000_0000_0000, 1);
      base = bytes_seen;
      wr(4'd7, 64'h11E3_00C0_3110_0000);
      wait_state(8'h01);
      chk("R9 branch reached send", 64'(bytes_seen - base), 64'd1);
      chk("R9 released after program", 64'(spi_cs_n), 64'hF);
      wr(4'd5, 64'h6600_0000_0000_0000);
      expect_bytes(64'h6600_0000_0000_0000, 1);
      wr(4'd7, 64'h1110_1110_1110_1131);
      wait_state(8'h01);
      repeat (2) @(negedge clk);
      chk("R9 last slot ends with select held", 64'(spi_cs_n), 64'hE);
      rd(4'd8, v); chk("R9 idle after slot 7", v, IDLE_ST);

      // R10 undefined opcode
      wr(4'd7, 64'h1155_3100_0000_0000);
      wait_state(8'h01);
      rd(4'd8, v); chk("R10 bad opcode flag", v, IDLE_ST | (64'd1 << 12));
      chk("R10 chip selects released", 64'(spi_cs_n), 64'hF);
      wr(4'd8, 64'd0);
      rd(4'd8, v); chk("R11 bad opcode flag cleared", v, IDLE_ST);

      // R11 abort key while parked
      expect_bytes(64'd0, 1);
      resp_q.push_back(8'hC5);
      prime();
      wr(4'd7, 64'h1141_3400_0000_0000);
      wait_state(8'h04);
      rd(4'd8, v); chk("R11 rx full before abort", 64'(v[63]), 64'd1);
      chk("R11 selected before abort", 64'(spi_cs_n), 64'hE);
      wr(4'd3, 64'h0000_0050_0000_0000);
      wr(4'd3, 64'h0000_00A0_0000_0000);
      rd(4'd8, v); chk("R11 status after abort", v, IDLE_ST);
      chk("R11 released after abort", 64'(spi_cs_n), 64'hF);
      rd(4'd3, v); chk("R11 clock cfg unchanged", v, CLKCFG);

      chk("R3 scoreboard drained", 64'(exp_q.size()), 64'd0);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

endmodule